// File: doc/BRIEF.md
# Source-Routed Header Stepper with Cut-Through

This block sits on one incoming link of a three-dimensional mesh router and looks at each packet as it arrives. Each packet carries its whole path in its first 80-bit word. That path is a list of up to six segments, each with a direction and a hop count, plus a small route state. The state records which segment is being walked and how many hops of it were already taken. From the first word alone, in the cycle that word is presented, the block works out three things: whether the packet keeps going straight, turns into another direction, or goes to the local processor.

When the packet goes straight and the straight output reports space, the block sends it down the fast pass-through path. In every other allowed case it hands the packet to the turn and queue logic, tagged with the direction it needs. A packet whose requested turn is not enabled in a programmable allow mask is dropped before it turns. A dropped packet raises a single-cycle pulse, and the block then swallows its remaining words.

The block also advances the route state in the header. It rewrites the low seven bits of the second word with the bitwise inverse of the new state, so that every wire keeps equal numbers of ones and zeros. Words flow with valid/ready handshakes and no storage. The input is accepted only when the chosen output takes the word, so a stalled output holds the input. Words of a dropped packet are always accepted.

Top module: `hdr_stepper`

## Requirements
- R1: Header layout: bits [2:0] are the active segment index and bits [6:3] the hops already taken on it. Segment n (n = 0..5) has its 3-bit direction at bit 7+7n and its 4-bit distance field at bit 10+7n. A distance field d means d+1 hops. Direction codes are 0=+X, 1=-X, 2=+Y, 3=-Y, 4=+Z, 5=-Z and 6=local; code 7 is never allowed. When the hop count is below the distance field, the forwarded header keeps the segment index and carries hop count + 1.
- R2: When the hop count equals the distance field, the segment finishes. The forwarded header carries segment index + 1 and hop count 0, and the packet leaves toward the next segment's direction.
- R3: Bits [6:0] of the second word of a packet leave as the bitwise inverse of the forwarded header's bits [6:0]. All other bits of every word, and all words after the second, pass unchanged.
- R4: A packet uses the straight output only when all three hold: its segment does not finish, the segment's direction equals the block's own direction `MY_DIR`, and `thru_free` is 1 while the header is presented. All its words then follow on that output.
- R5: Every other allowed packet goes out on the divert output. On its header and all later words, `div_dir` holds the direction the packet needs.
- R6: A packet goes to the local processor (`div_dir` = 6) in three cases. Its segment finishes and the next direction is 6. Its finishing segment is segment 5. Or it enters with a segment index of 6 or 7, in which case its header passes unchanged.
- R7: If the departure direction differs from `MY_DIR` and is 7 or has a clear bit in `turn_allow` (bit k enables code k), the packet is dropped. `drop_pulse` is high for exactly the header's cycle. No word of the packet appears on either output, and `in_ready` stays 1 until its last word.
- R8: While the selected output is not ready, `in_ready` is 0. The output keeps presenting the same word.
- R9: After reset, and after any word accepted with `in_last` = 1, the next word is taken as a header. Right after reset both output valids and `drop_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| turn_allow | input | 7 | Enable bit per departure direction code 0..6 |
| thru_free | input | 1 | Straight output has buffer space |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 80 | Input word |
| in_last | input | 1 | Last word of the packet |
| thru_valid | output | 1 | Straight output valid |
| thru_ready | input | 1 | Straight output ready |
| thru_data | output | 80 | Straight output word |
| thru_last | output | 1 | Straight output last word |
| div_valid | output | 1 | Divert output valid |
| div_ready | input | 1 | Divert output ready |
| div_data | output | 80 | Divert output word |
| div_last | output | 1 | Divert output last word |
| div_dir | output | 3 | Direction requested by the diverted packet |
| drop_pulse | output | 1 | One-cycle pulse on a dropped header |

## Verification
The assertions assume that the sender holds `in_data`, `in_last` and `in_valid` steady while a word waits. They also assume that `thru_free` and `turn_allow` do not change while a header waits, since the route is chosen combinationally from those inputs. The stimulus sets both per packet before presenting the header and changes input words only after the handshake. During stalls it lowers both ready inputs and leaves the header in place. The sweep covers every segment index, current and next direction code, finishing and non-finishing hop counts, and both `thru_free` values under two allow masks.

// File: rtl/hdr_step_pkg.sv
package hdr_step_pkg;
  localparam int STATE_W    = 7;
  localparam int DIR_W      = 3;
  localparam int DIST_W     = 4;
  localparam int SEG_BASE   = 7;
  localparam int SEG_STRIDE = DIR_W + DIST_W;
  localparam logic [DIR_W-1:0] DIR_LOCAL = 3'd6;

  typedef enum logic [1:0] {
    RT_THRU = 2'd0,
    RT_DIV  = 2'd1,
    RT_DROP = 2'd2
  } route_t;

  typedef enum logic [1:0] {
    POS_HDR  = 2'd0,
    POS_COMP = 2'd1,
    POS_BODY = 2'd2
  } wpos_t;

  // packed: hop lands in [6:3], segment index in [2:0]
  typedef struct packed {
    logic [DIST_W-1:0] hop;
    logic [2:0]        seg;
  } rstate_t;
endpackage

// File: rtl/hdr_decode.sv
module hdr_decode
  import hdr_step_pkg::*;
#(
  parameter int WORD_W   = 80,
  parameter int NUM_SEGS = 6
) (
  input  logic [WORD_W-1:0] hdr,
  output rstate_t           next_state,
  output logic [DIR_W-1:0]  out_dir,
  output logic              finishing,
  output logic              past_end
);
  localparam int SEG_END = SEG_BASE + SEG_STRIDE * NUM_SEGS;

  logic [DIR_W-1:0]  seg_dir  [NUM_SEGS];
  logic [DIST_W-1:0] seg_dist [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_field
    assign seg_dir[g]  = hdr[SEG_BASE + SEG_STRIDE*g +: DIR_W];
    assign seg_dist[g] = hdr[SEG_BASE + SEG_STRIDE*g + DIR_W +: DIST_W];
  end

  rstate_t    cur;
  logic [3:0] seg_nx;

  always_comb begin
    cur        = rstate_t'(hdr[STATE_W-1:0]);
    seg_nx     = {1'b0, cur.seg} + 4'd1;
    past_end   = ({1'b0, cur.seg} >= 4'(NUM_SEGS));
    next_state = cur;
    out_dir    = DIR_LOCAL;
    finishing  = 1'b0;
    if (!past_end) begin
      finishing = (cur.hop == seg_dist[cur.seg]);
      if (finishing) begin
        next_state.seg = seg_nx[2:0];
        next_state.hop = '0;
        out_dir = (seg_nx >= 4'(NUM_SEGS)) ? DIR_LOCAL : seg_dir[seg_nx[2:0]];
      end else begin
        next_state.hop = cur.hop + 4'd1;
        out_dir        = seg_dir[cur.seg];
      end
    end
  end

  initial begin
    if (SEG_END > WORD_W) $error("segment fields exceed word width");
  end
endmodule

// File: rtl/route_select.sv
module route_select
  import hdr_step_pkg::*;
#(
  parameter int MY_DIR = 0
) (
  input  logic [DIR_W-1:0] out_dir,
  input  logic             finishing,
  input  logic             past_end,
  input  logic             thru_free,
  input  logic [6:0]       turn_allow,
  output route_t           route
);
  localparam logic [DIR_W-1:0] OWN = DIR_W'(MY_DIR);

  logic straight, legal;

  always_comb begin
    straight = !past_end && !finishing && (out_dir == OWN);
    legal    = (out_dir == OWN) ||
               ((out_dir != 3'd7) && turn_allow[out_dir]);
    if (!legal)                     route = RT_DROP;
    else if (straight && thru_free) route = RT_THRU;
    else                            route = RT_DIV;
  end
endmodule

// File: rtl/pkt_tracker.sv
module pkt_tracker
  import hdr_step_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             last,
  input  route_t           hdr_route,
  input  rstate_t          hdr_state,
  input  logic [DIR_W-1:0] hdr_dir,
  output wpos_t            pos,
  output route_t           route_q,
  output rstate_t          state_q,
  output logic [DIR_W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= POS_HDR;
      route_q <= RT_DIV;
      state_q <= '0;
      dir_q   <= '0;
    end else if (accept) begin
      if (pos == POS_HDR) begin
        route_q <= hdr_route;
        state_q <= hdr_state;
        dir_q   <= hdr_dir;
      end
      if (last)                 pos <= POS_HDR;
      else if (pos == POS_HDR)  pos <= POS_COMP;
      else                      pos <= POS_BODY;
    end
  end

  AST_REARM_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && last |=> pos == POS_HDR); // R9
endmodule

// File: rtl/hdr_stepper.sv
module hdr_stepper
  import hdr_step_pkg::*;
#(
  parameter int WORD_W   = 80,
  parameter int NUM_SEGS = 6,
  parameter int MY_DIR   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        turn_allow,
  input  logic              thru_free,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              thru_valid,
  input  logic              thru_ready,
  output logic [WORD_W-1:0] thru_data,
  output logic              thru_last,
  output logic              div_valid,
  input  logic              div_ready,
  output logic [WORD_W-1:0] div_data,
  output logic              div_last,
  output logic [DIR_W-1:0]  div_dir,
  output logic              drop_pulse
);
  rstate_t          hdr_state, state_q;
  logic [DIR_W-1:0] hdr_dir, dir_q;
  logic             hdr_fin, hdr_past;
  route_t           hdr_route, route_q, route_now;
  wpos_t            pos;
  logic             is_hdr;
  logic [WORD_W-1:0] out_word;

  hdr_decode #(.WORD_W(WORD_W), .NUM_SEGS(NUM_SEGS)) u_dec (
    .hdr(in_data), .next_state(hdr_state), .out_dir(hdr_dir),
    .finishing(hdr_fin), .past_end(hdr_past)
  );

  route_select #(.MY_DIR(MY_DIR)) u_sel (
    .out_dir(hdr_dir), .finishing(hdr_fin), .past_end(hdr_past),
    .thru_free(thru_free), .turn_allow(turn_allow), .route(hdr_route)
  );

  pkt_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .accept(in_valid && in_ready), .last(in_last),
    .hdr_route(hdr_route), .hdr_state(hdr_state), .hdr_dir(hdr_dir),
    .pos(pos), .route_q(route_q), .state_q(state_q), .dir_q(dir_q)
  );

  assign is_hdr    = (pos == POS_HDR);
  assign route_now = is_hdr ? hdr_route : route_q;

  always_comb begin
    out_word = in_data;
    if (is_hdr)               out_word[STATE_W-1:0] = hdr_state;
    else if (pos == POS_COMP) out_word[STATE_W-1:0] = ~state_q;
  end

  always_comb begin
    case (route_now)
      RT_THRU: in_ready = thru_ready;
      RT_DIV:  in_ready = div_ready;
      default: in_ready = 1'b1;
    endcase
  end

  assign thru_valid = in_valid && (route_now == RT_THRU);
  assign div_valid  = in_valid && (route_now == RT_DIV);
  assign thru_data  = out_word;
  assign div_data   = out_word;
  assign thru_last  = in_last;
  assign div_last   = in_last;
  assign div_dir    = is_hdr ? hdr_dir : dir_q;
  assign drop_pulse = in_valid && is_hdr && (hdr_route == RT_DROP);

  AST_THRU_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    thru_valid && is_hdr |-> thru_free); // R4
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !is_hdr && route_q == RT_DROP |-> !thru_valid && !div_valid); // R7
  AST_DROP_SINKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && route_now == RT_DROP |-> in_ready); // R7
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid && !div_ready |=> div_valid && $stable(div_data)); // R8
  AST_THRU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    thru_valid && !thru_ready |=> thru_valid && $stable(thru_data)); // R8
endmodule

// File: tb/hdr_stepper_test.sv
`timescale 1ns/1ps
module hdr_stepper_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  turn_allow = '0;
  logic        thru_free = 0;
  logic        in_valid = 0, in_last = 0;
  logic [79:0] in_data = '0;
  logic        in_ready;
  logic        thru_valid, thru_last, div_valid, div_last, drop_pulse;
  logic        thru_ready = 1, div_ready = 1;
  logic [79:0] thru_data, div_data;
  logic [2:0]  div_dir;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hdr_stepper uut (.*);

  task automatic chk(input logic ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // rt: 0 straight, 1 divert, 2 dropped
  task automatic look(input int rt, input logic [79:0] ed, input logic el, input logic [2:0] edir,
                      input logic edrop, input string req);
    chk(thru_valid == (rt == 0), {req, " R4 thru_valid"}, 80'(thru_valid), 80'(rt == 0));
    chk(div_valid == (rt == 1), {req, " R5 div_valid"}, 80'(div_valid), 80'(rt == 1));
    chk(drop_pulse == edrop, {req, " R7 drop_pulse"}, 80'(drop_pulse), 80'(edrop));
    if (rt == 0) begin
      chk(thru_data == ed, {req, " thru_data"}, thru_data, ed);
      chk(thru_last == el, {req, " thru_last"}, 80'(thru_last), 80'(el));
    end
    if (rt == 1) begin
      chk(div_data == ed, {req, " div_data"}, div_data, ed);
      chk(div_last == el, {req, " div_last"}, 80'(div_last), 80'(el));
      chk(div_dir == edir, {req, " R5 div_dir"}, 80'(div_dir), 80'(edir));
    end
  endtask

  task automatic send(input logic [79:0] d, input logic last, input int rt, input logic [79:0] ed,
                      input logic [2:0] edir, input logic edrop, input bit stall, input string req);
    @(negedge clk);
    in_valid = 1; in_data = d; in_last = last;
    if (stall && rt != 2) begin
      thru_ready = 0; div_ready = 0;
      #1;
      chk(in_ready == 0, "R8 stalled in_ready", 80'(in_ready), 80'(0));
      look(rt, ed, last, edir, edrop, {req, " stall"});
      @(negedge clk);
      look(rt, ed, last, edir, edrop, {req, " R8 held"});
      thru_ready = 1; div_ready = 1;
    end
    #1;
    look(rt, ed, last, edir, edrop, req);
    chk(in_ready == 1, {req, " in_ready"}, 80'(in_ready), 80'(1));
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(!thru_valid && !div_valid && !drop_pulse, "R9 reset outputs", {thru_valid, div_valid, drop_pulse}, 80'(0));
    for (int seg = 0; seg < 8; seg++)
      for (int cd = 0; cd < 8; cd++)
        for (int nd = 0; nd < 8; nd++)
          for (int fin = 0; fin < 2; fin++)
            for (int fr = 0; fr < 2; fr++) begin
              automatic int k = (((seg*8 + cd)*8 + nd)*2 + fin)*2 + fr;
              automatic int hop = (seg*5 + cd + nd) % 15;
              automatic logic [79:0] h, w1, w2, eh, ew1;
              automatic logic [6:0] ns;
              automatic int od, rt;
              automatic bit f, pe, one_word, stall;
              automatic string tag;
              h = {16'hA5C3 ^ 16'(k), 64'h0123_4567_89AB_CDEF};
              for (int s = 0; s < 6; s++) begin
                h[7+7*s +: 3]  = 3'((s + 3) % 7);
                h[10+7*s +: 4] = 4'((s * 3) % 16);
              end
              if (seg < 6) begin
                h[7+7*seg +: 3]  = 3'(cd);
                h[10+7*seg +: 4] = 4'(fin ? hop : hop + 1);
                if (seg < 5) begin
                  h[7+7*(seg+1) +: 3]  = 3'(nd);
                  h[10+7*(seg+1) +: 4] = 4'd2;
                end
              end
              h[6:0] = {4'(hop), 3'(seg)};
              pe = (seg >= 6);
              f  = !pe && fin;
              if (pe)      begin ns = h[6:0]; od = 6; end                       // R6
              else if (f)  begin ns = {4'd0, 3'(seg + 1)}; od = (seg == 5) ? 6 : nd; end // R2
              else         begin ns = {4'(hop + 1), 3'(seg)}; od = cd; end       // R1
              turn_allow = k[3] ? 7'b1010101 : 7'b0111110;
              thru_free  = fr[0];
              if (od != 0 && (od == 7 || !turn_allow[od])) rt = 2;              // R7
              else if (!pe && !f && od == 0 && fr == 1) rt = 0;                 // R4
              else rt = 1;
              eh = h; eh[6:0] = ns;
              w1 = {80{1'b1}} ^ {16'(k), 64'hFEDC_BA98_7654_3210};
              w1[6:0] = ~h[6:0];
              ew1 = w1; ew1[6:0] = ~ns;                                         // R3
              w2 = {40'h5A5A_5A5A_5A, 40'(k)};
              one_word = (k % 7 == 3);
              stall = (k % 5 == 0);
              tag = $sformatf("R1 R2 R6 k=%0d hdr", k);
              send(h, one_word, rt, (rt == 2) ? 80'(0) : eh, 3'(od), rt == 2, stall, tag);
              if (!one_word) begin
                send(w1, 0, rt, ew1, 3'(od), 0, stall, $sformatf("R3 k=%0d w1", k));
                send(w2, 1, rt, w2, 3'(od), 0, 0, $sformatf("R3 R9 k=%0d w2", k));
              end
              @(negedge clk); in_valid = 0;
            end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule